// File: doc/BRIEF.md
# Interrupt Vector Fetch Sequencer

This block steps an 8-bit processor through the entry sequence of a break or interrupt, cycle by cycle. A request seen in the fetch state (T1) starts the timing states T2, T3, T4, T5, T6 and T0. The sequence then returns to T1 at the handler address. The two reads of the jump vector are commanded in T5 (low byte) and T6 (high byte). Each command reaches the address bus one cycle after it is issued, so the low-byte read is on the bus during T6 and the high-byte read during T0. Stack traffic is not modelled: outside the vector reads the bus holds the current program address.

The vector is not fixed when the sequence starts. It is chosen again for each byte: reset first, then a pending NMI, then IRQ or soft break. This allows a late NMI to take over a sequence that an IRQ started. To stop an NMI from supplying only the high byte, NMI recognition is gated off from T5 to the end of T0. Reset has no such gate, so a badly timed reset can mix vector bytes or collapse T6 and T0 into a single cycle. These cases are modelled on purpose, so that a system bench can reproduce them.

A reset or NMI line "is seen" in a cycle when it was sampled low at the clock edge that began that cycle. The whole block also has a synchronous active-high reset `rst` of its own.

Top module: `irq_vector_seq`

## Requirements
- R1: A request seen in T1 (reset seen, NMI pending, `irq_n` low or `brk_req` high) leads through T2..T6 and T0 back to T1. In that T1 cycle, seven cycles after the request cycle, `done` is high for exactly one cycle, `handler` holds the assembled address and `addr` equals it.
- R2: With no reset and no NMI, the low byte is read from FFFE while in T6 and the high byte from FFFF while in T0. `handler` is {byte at FFFF, byte at FFFE}.
- R3: A falling edge on `nmi_n` makes an NMI pending, and the NMI vector is read at FFFA/FFFB. `vec_sel` shows the vector of the byte on the bus: 1 NMI, 2 reset, 3 IRQ/soft break, and 0 in every cycle that is not a vector read.
- R4: The vector is chosen separately for each byte, with reset over NMI over IRQ. If NMI takes the low byte and reset is seen only in T6, the result is {reset high, NMI low}. If reset is seen in both T5 and T6, the reset vector wins over a pending NMI.
- R5: An NMI edge sampled at or before the end of T4 sends both bytes to the NMI vector, even in a sequence started by IRQ or soft break.
- R6: An NMI edge that arrives in T5, T6 or T0 is ignored until the end of the following T1. If the line is still low then, a new sequence starts one cycle after `done` and uses the NMI vector.
- R7: An NMI line that falls in T5 and rises again before the end of the next T1 is lost: no further sequence follows.
- R8: A reset seen in T6 only takes the high byte from FFFD and keeps the IRQ low byte (F9 and 30 give F930). A reset seen first in T0 does not change the current sequence.
- R9: A reset seen in T5 with the line already high again during T5 merges T6 and T0 into one cycle that reads FFFC. The next cycle is T1 at {byte at FFFC, FD}, and `done` comes six cycles after the request.
- R10: A reset seen in both T5 and T6 reads FFFC and FFFD and gives the full reset handler.
- R11: Using the NMI vector clears the pending NMI. A line held low afterwards produces no second sequence.
- R12: After `rst`, the block is in T1 with `addr` and `handler` equal to the RESET_PC parameter (default 0200), `done` low and `vec_sel` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| res_n | input | 1 | Processor reset line, active low |
| nmi_n | input | 1 | Non-maskable interrupt line, active low, edge-sensitive |
| irq_n | input | 1 | Maskable interrupt line, active low |
| brk_req | input | 1 | Soft-break trigger, seen in T1 |
| rdata | input | 8 | Read data for the current address |
| addr | output | 16 | Address bus |
| vec_sel | output | 2 | Vector of the byte being read (0 none, 1 NMI, 2 reset, 3 IRQ/break) |
| handler | output | 16 | Assembled handler address |
| done | output | 1 | One-cycle pulse when the handler address is complete |

## Verification
Each sequence is started by IRQ or soft break and gets no late interrupt, an NMI falling in T3, T4 or T5, a reset line low in T4, T5 or T6 for one or two cycles, or both at once. The handler addresses tell the outcomes apart: a clean IRQ (FA30), a full NMI takeover (F810), a half merge (F930, F910), a collapsed cycle (20FD) and a full reset (F920). The bus addresses in T6 and T0 show which vector each byte came from. Separate runs cover an NMI alone, and an NMI held or released across the lockout window, to tell a delayed NMI apart from a lost one.

// File: rtl/ivs_pkg.sv
package ivs_pkg;

    localparam int DW = 8;
    localparam int AW = 2 * DW;

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_RUN = 3'd0,   // T1: opcode fetch
        ST_T2  = 3'd1,
        ST_T3  = 3'd2,
        ST_T4  = 3'd3,
        ST_T5  = 3'd4,   // low-byte command issued
        ST_T6  = 3'd5,   // high-byte command issued, low byte on bus
        ST_T0  = 3'd6,   // high byte on bus
        ST_T60 = 3'd7    // T6 and T0 merged by a short reset
    } tstate_e;

    typedef enum logic [1:0] {
        VEC_NONE = 2'd0,
        VEC_NMI  = 2'd1,
        VEC_RES  = 2'd2,
        VEC_IRQ  = 2'd3
    } vec_e;

    typedef struct packed {
        vec_e  v_lo;
        vec_e  v_hi;
        byte_t lo;
    } vfetch_t;

    function automatic vec_e vec_pick(input logic res, input logic nmi);
        if (res)      return VEC_RES;
        else if (nmi) return VEC_NMI;
        else          return VEC_IRQ;
    endfunction

    function automatic byte_t vec_low(input vec_e v);
        byte_t ones;
        ones = '1;
        case (v)
            VEC_NMI: return ones - byte_t'(5);
            VEC_RES: return ones - byte_t'(3);
            default: return ones - byte_t'(1);
        endcase
    endfunction

    function automatic logic in_lock(input tstate_e s);
        return (s == ST_T5) || (s == ST_T6) || (s == ST_T0) || (s == ST_T60);
    endfunction

endpackage

// File: rtl/ivs_nmi_latch.sv
module ivs_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n,
    input  logic lock,
    input  logic clear,
    output logic pend
);

    logic prev_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            if (!lock) begin
                prev_q <= nmi_n;
            end
            if (!lock && prev_q && !nmi_n) begin
                pend_q <= 1'b1;
            end else if (clear) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign pend = pend_q;

    AST_NMI_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        lock |=> !$rose(pend_q)); // R6

    AST_NMI_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clear |=> !pend_q); // R11

endmodule

// File: rtl/ivs_timing.sv
module ivs_timing
    import ivs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    collide,
    output tstate_e state
);

    tstate_e st_q;
    tstate_e st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_RUN:  st_d = start ? ST_T2 : ST_RUN;
            ST_T2:   st_d = ST_T3;
            ST_T3:   st_d = ST_T4;
            ST_T4:   st_d = ST_T5;
            ST_T5:   st_d = collide ? ST_T60 : ST_T6;
            ST_T6:   st_d = ST_T0;
            ST_T0:   st_d = ST_RUN;
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RUN;
        else     st_q <= st_d;
    end

    assign state = st_q;

    AST_RUN_TO_T2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && start) |=> (st_q == ST_T2)); // R1

    AST_T4_TO_T5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_T4) |=> (st_q == ST_T5)); // R1

    AST_T6_TO_T0: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_T6) |=> (st_q == ST_T0)); // R1

endmodule

// File: rtl/ivs_vector_path.sv
module ivs_vector_path
    import ivs_pkg::*;
#(
    parameter addr_t RESET_PC = 16'h0200
) (
    input  logic    clk,
    input  logic    rst,
    input  tstate_e state,
    input  logic    res_act,
    input  logic    nmi_act,
    input  byte_t   rdata,
    output addr_t   addr,
    output vec_e    vsel,
    output addr_t   handler,
    output logic    done,
    output logic    nmi_used
);

    localparam byte_t VEC_PAGE = '1;

    vfetch_t vf_q;
    addr_t   pc_q;
    logic    done_q;
    vec_e    pick;

    assign pick = vec_pick(res_act, nmi_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            vf_q   <= '{v_lo: VEC_NONE, v_hi: VEC_NONE, lo: '0};
            pc_q   <= RESET_PC;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_T5: vf_q.v_lo <= pick;
                ST_T6: begin
                    vf_q.v_hi <= pick;
                    vf_q.lo   <= rdata;
                end
                ST_T0: begin
                    pc_q   <= {rdata, vf_q.lo};
                    done_q <= 1'b1;
                end
                ST_T60: begin
                    pc_q   <= {rdata, vec_low(vf_q.v_lo) | byte_t'(1)};
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_T6, ST_T60: begin
                addr = {VEC_PAGE, vec_low(vf_q.v_lo)};
                vsel = vf_q.v_lo;
            end
            ST_T0: begin
                addr = {VEC_PAGE, vec_low(vf_q.v_hi) | byte_t'(1)};
                vsel = vf_q.v_hi;
            end
            default: begin
                addr = pc_q;
                vsel = VEC_NONE;
            end
        endcase
    end

    assign nmi_used = (state == ST_T6) && (vf_q.v_lo == VEC_NMI || pick == VEC_NMI);
    assign handler  = pc_q;
    assign done     = done_q;

    AST_VEC_PAGE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T6 || state == ST_T0) |-> (addr[AW-1:DW] == VEC_PAGE)); // R2

    AST_HI_ODD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T0) |-> addr[0]); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R1

    AST_RES_WINS_HI: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T6 && res_act) |=> (vsel == VEC_RES)); // R4

endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
    import ivs_pkg::*;
#(
    parameter addr_t RESET_PC = 16'h0200
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          res_n,
    input  logic          nmi_n,
    input  logic          irq_n,
    input  logic          brk_req,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic [1:0]    vec_sel,
    output logic [AW-1:0] handler,
    output logic          done
);

    tstate_e state;
    vec_e    vsel;
    logic    res_q;
    logic    nmi_pend;
    logic    nmi_used;
    logic    start;
    logic    collide;

    always_ff @(posedge clk) begin
        if (rst) res_q <= 1'b0;
        else     res_q <= !res_n;
    end

    assign start   = res_q | nmi_pend | !irq_n | brk_req;
    assign collide = res_q & res_n;

    ivs_timing i_timing (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .collide (collide),
        .state   (state)
    );

    ivs_nmi_latch i_nmi (
        .clk   (clk),
        .rst   (rst),
        .nmi_n (nmi_n),
        .lock  (in_lock(state)),
        .clear (nmi_used),
        .pend  (nmi_pend)
    );

    ivs_vector_path #(.RESET_PC(RESET_PC)) i_path (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .res_act  (res_q),
        .nmi_act  (nmi_pend),
        .rdata    (rdata),
        .addr     (addr),
        .vsel     (vsel),
        .handler  (handler),
        .done     (done),
        .nmi_used (nmi_used)
    );

    assign vec_sel = vsel;

    AST_DONE_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state == ST_T0 || state == ST_T60)); // R1

    AST_ADDR_IS_HANDLER: assert property (@(posedge clk) disable iff (rst)
        done |-> (addr == handler)); // R1

endmodule

// File: tb/test_irq_vector_seq.sv
`timescale 1ns/1ps
module test_irq_vector_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_n = 1'b1;
    logic        nmi_n = 1'b1;
    logic        irq_n = 1'b1;
    logic        brk_req = 1'b0;
    logic [7:0]  rdata;
    logic [15:0] addr;
    logic [1:0]  vec_sel;
    logic [15:0] handler;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_vector_seq i_irq_vector_seq (
        .clk     (clk),
        .rst     (rst),
        .res_n   (res_n),
        .nmi_n   (nmi_n),
        .irq_n   (irq_n),
        .brk_req (brk_req),
        .rdata   (rdata),
        .addr    (addr),
        .vec_sel (vec_sel),
        .handler (handler),
        .done    (done)
    );

    // memory model: vector bytes, everything else a filler byte
    always_comb begin
        case (addr)
            16'hFFFA: rdata = 8'h10;
            16'hFFFB: rdata = 8'hF8;
            16'hFFFC: rdata = 8'h20;
            16'hFFFD: rdata = 8'hF9;
            16'hFFFE: rdata = 8'h30;
            16'hFFFF: rdata = 8'hFA;
            default:  rdata = 8'hEA;
        endcase
    end

    typedef struct packed {
        bit        irq;
        bit        brk;
        int        ns;
        int        ne;
        int        rs;
        int        re;
        bit [15:0] hnd;
        int        dcyc;
        bit [15:0] a5;
        bit [15:0] a6;
    } scen_t;

    localparam int NSCEN = 10;
    localparam scen_t SCEN [NSCEN] = '{
        '{1'b1, 1'b0, -1, -1, -1, -1, 16'hFA30, 7, 16'hFFFE, 16'hFFFF},
        '{1'b0, 1'b1, -1, -1, -1, -1, 16'hFA30, 7, 16'hFFFE, 16'hFFFF},
        '{1'b1, 1'b0,  3, 40, -1, -1, 16'hF810, 7, 16'hFFFA, 16'hFFFB},
        '{1'b1, 1'b0,  2, 40, -1, -1, 16'hF810, 7, 16'hFFFA, 16'hFFFB},
        '{1'b1, 1'b0, -1, -1,  4,  4, 16'hF930, 7, 16'hFFFE, 16'hFFFD},
        '{1'b1, 1'b0, -1, -1,  3,  3, 16'h20FD, 6, 16'hFFFC, 16'h20FD},
        '{1'b1, 1'b0, -1, -1,  3,  4, 16'hF920, 7, 16'hFFFC, 16'hFFFD},
        '{1'b1, 1'b0, -1, -1,  5,  5, 16'hFA30, 7, 16'hFFFE, 16'hFFFF},
        '{1'b1, 1'b0,  3, 40,  4,  4, 16'hF910, 7, 16'hFFFA, 16'hFFFD},
        '{1'b1, 1'b0,  2, 40,  3,  4, 16'hF920, 7, 16'hFFFC, 16'hFFFD}
    };

    function automatic string row_req(input int i);
        case (i)
            0:       return "R2";
            1:       return "R2";
            2:       return "R5";
            3:       return "R5";
            4:       return "R8";
            5:       return "R9";
            6:       return "R10";
            7:       return "R8";
            default: return "R4";
        endcase
    endfunction

    logic [15:0] addr_log [0:31];
    logic [1:0]  vec_log  [0:31];
    int          done_cnt;
    int          d1_cyc;
    int          d2_cyc;
    logic [15:0] d1_hnd;
    logic [15:0] d2_hnd;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic block_reset();
        rst = 1'b1;
        res_n = 1'b1; nmi_n = 1'b1; irq_n = 1'b1; brk_req = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // cycle k: outputs sampled at the negedge inside cycle k, inputs for cycle k driven there
    task automatic do_run(input bit irq0, input bit brk0, input int ns, input int ne,
                          input int rs, input int re, input int n);
        block_reset();
        done_cnt = 0; d1_cyc = -1; d2_cyc = -1; d1_hnd = '0; d2_hnd = '0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            addr_log[k] = addr;
            vec_log[k]  = vec_sel;
            if (done) begin
                done_cnt++;
                if (done_cnt == 1) begin d1_cyc = k; d1_hnd = handler; end
                else if (done_cnt == 2) begin d2_cyc = k; d2_hnd = handler; end
            end
            irq_n   = !(irq0 && k == 0);
            brk_req = brk0 && (k == 0);
            nmi_n   = !(k >= ns && k <= ne);
            res_n   = !(k >= rs && k <= re);
        end
        @(negedge clk);
        res_n = 1'b1; nmi_n = 1'b1; irq_n = 1'b1; brk_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R12: state after block reset
        block_reset();
        @(negedge clk);
        chk("R12", "addr after reset", 32'(addr), 32'h0200);
        chk("R12", "handler after reset", 32'(handler), 32'h0200);
        chk("R12", "done after reset", 32'(done), 32'h0);
        chk("R12", "vec_sel after reset", 32'(vec_sel), 32'h0);

        // table of scenarios, one loop
        for (int i = 0; i < NSCEN; i++) begin
            do_run(SCEN[i].irq, SCEN[i].brk, SCEN[i].ns, SCEN[i].ne,
                   SCEN[i].rs, SCEN[i].re, 13);
            chk(row_req(i), $sformatf("row %0d done count", i), 32'(done_cnt), 32'd1);
            chk("R1", $sformatf("row %0d done cycle", i), 32'(d1_cyc), 32'(SCEN[i].dcyc));
            chk(row_req(i), $sformatf("row %0d handler", i), 32'(d1_hnd), 32'(SCEN[i].hnd));
            chk(row_req(i), $sformatf("row %0d addr in cycle 5", i), 32'(addr_log[5]), 32'(SCEN[i].a5));
            chk(row_req(i), $sformatf("row %0d addr in cycle 6", i), 32'(addr_log[6]), 32'(SCEN[i].a6));
        end

        // R1: fetch at the handler in the done cycle; R3: vec_sel codes
        do_run(1'b1, 1'b0, -1, -1, -1, -1, 10);
        chk("R1", "addr in done cycle", 32'(addr_log[7]), 32'hFA30);
        chk("R3", "vec_sel in T6 for IRQ", 32'(vec_log[5]), 32'd3);
        chk("R3", "vec_sel outside vector reads", 32'(vec_log[3]), 32'd0);

        // R3 / R11: NMI alone, line held low afterwards
        do_run(1'b0, 1'b0, 0, 40, -1, -1, 22);
        chk("R3", "nmi-only done cycle", 32'(d1_cyc), 32'd8);
        chk("R3", "nmi-only handler", 32'(d1_hnd), 32'hF810);
        chk("R3", "nmi-only low read addr", 32'(addr_log[6]), 32'hFFFA);
        chk("R3", "nmi-only vec_sel in T6", 32'(vec_log[6]), 32'd1);
        chk("R11", "held nmi gives one sequence", 32'(done_cnt), 32'd1);

        // R6: NMI falling in T5 and held: delayed to the next T1
        do_run(1'b1, 1'b0, 4, 40, -1, -1, 22);
        chk("R6", "first handler is IRQ", 32'(d1_hnd), 32'hFA30);
        chk("R6", "handler fetch ran first", 32'(addr_log[7]), 32'hFA30);
        chk("R6", "second sequence count", 32'(done_cnt), 32'd2);
        chk("R6", "second done cycle", 32'(d2_cyc), 32'd15);
        chk("R6", "second handler is NMI", 32'(d2_hnd), 32'hF810);
        chk("R6", "no NMI low read in first sequence", 32'(addr_log[5]), 32'hFFFE);

        // R7: NMI falling in T5, released before T1 ends: lost
        do_run(1'b1, 1'b0, 4, 6, -1, -1, 22);
        chk("R7", "lost nmi done count", 32'(done_cnt), 32'd1);
        chk("R7", "lost nmi handler", 32'(d1_hnd), 32'hFA30);
        chk("R7", "bus stays at handler", 32'(addr_log[20]), 32'hFA30);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule